// File: doc/BRIEF.md
# Windowed Watchdog with Shared Prescaler Control

This block is a windowed watchdog timer. Each period is a configurable multiple of a base length, and that base length is counted in pulses of an external tick. The period has two halves. During the first half a clear is not allowed (the window is closed). During the second half a clear is accepted and starts a new period. The block reports a fault in two cases: the period runs out with no clear, or a clear arrives while the window is closed. On a fault it issues a single-cycle reset request, sets sticky status flags and starts the period again.

Software reaches the block through two ports. The first is a byte-wide write port for a control register that is shared between two uses. A select bit decides whether the low three bits load the watchdog prescaler or the prescaler for the periodic wake-up sensing. The second is a read port for a four-bit status register. Every access, whether a read or a control write, returns the current status on the same cycle and clears the timeout flag. After power-on the watchdog stays disarmed and reports itself as off. The first write to the watchdog prescaler arms it.

Top module: `winwdog`

## Requirements
- R1: After reset the status byte reads 0x02 (only the off bit set), `rstReq` is low and `cycCode` is 0.
- R2: On a control write, bit 3 selects the target. When bit 3 is 0, bits 2:0 load the watchdog prescaler, arm the watchdog and restart the period. When bit 3 is 1, bits 2:0 load `cycCode` and leave the running watchdog period untouched.
- R3: The prescaler codes 0 to 7 give dividers 1, 2, 4, 6, 8, 10, 12 and 14. The period L is BASE_TICKS times the divider, counted in `tick` pulses. Without a clear, `rstReq` rises on the L-th tick after the period restarts.
- R4: The window is closed while fewer than L/2 ticks of the current period have elapsed and open after that. Status bit 0 shows 1 while the window is open and the watchdog is armed.
- R5: A `wdClear` while the window is open restarts the period, so the next timeout comes L ticks later.
- R6: A `wdClear` while the window is closed is a fault.
- R7: A fault raises `rstReq` for exactly the next cycle, sets status bit 3 (timeout) and bit 2 (error), and restarts the period.
- R8: A cycle with `regRdEn` or `regWrEn` high clears the timeout bit. If a fault occurs in the same cycle, the fault wins and the bit stays set.
- R9: `regRdData` is {4'b0, timeout, error, off, windowOpen}. During an access it shows the status from before that access takes effect.
- R10: The error bit stays set until a clear is accepted in the open window.
- R11: While the watchdog is disarmed, `tick` and `wdClear` have no effect and no reset request is made.
- R12: The period counter advances only on cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| tick | input | 1 | Base timing pulse |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control write byte: bit 3 select, bits 2:0 code |
| regRdEn | input | 1 | Status register read strobe |
| regRdData | output | 8 | Status byte returned on any access |
| wdClear | input | 1 | Watchdog clear strobe |
| rstReq | output | 1 | One-cycle reset request on a fault |
| cycCode | output | 3 | Current periodic-sense prescaler code |

## Verification
The hardest cases to reach from the ports are the coincidences. One is a status read landing on the exact tick that expires the period. Another is a clear landing on the first or last tick of the closed half. The bench holds `tick` high so that the internal count follows the edge count exactly. It can then place a read or a clear on a chosen edge after a known restart. It also checks the window bit on both sides of the boundary, and it pauses `tick` to show that the count freezes.

// File: rtl/winwdog_pkg.sv
package winwdog_pkg;
  localparam int SEL_BIT  = 3;
  localparam int CODE_W   = 3;
  localparam int N_CODES  = 1 << CODE_W;
  localparam int DIV_W    = 4;
  localparam int ST_TO    = 3;
  localparam int ST_ERR   = 2;
  localparam int ST_OFF   = 1;
  localparam int ST_OPEN  = 0;

  typedef struct packed {
    logic loadWd;
    logic loadCyc;
    logic restart;
    logic fault;
    logic clrTo;
    logic clrErr;
  } wdStrobe_t;
endpackage

// File: rtl/winwdog_ctrl.sv
module winwdog_ctrl
  import winwdog_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      selCyc,
  input  logic      regRdEn,
  input  logic      wdClear,
  input  logic      armed,
  input  logic      winOpen,
  input  logic      expire,
  output wdStrobe_t strobe,
  output logic      rstReq
);
  logic clrOk, clrBad, loadWd;

  always_comb begin
    loadWd = regWrEn & ~selCyc;
    clrOk  = wdClear & armed & winOpen & ~loadWd;
    clrBad = wdClear & armed & ~winOpen & ~loadWd;
    strobe.loadWd  = loadWd;
    strobe.loadCyc = regWrEn & selCyc;
    strobe.fault   = clrBad | (expire & ~wdClear & armed & ~loadWd);
    strobe.restart = loadWd | clrOk | strobe.fault;
    strobe.clrTo   = regWrEn | regRdEn;
    strobe.clrErr  = clrOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstReq <= 1'b0;
    else       rstReq <= strobe.fault;
  end

  // R7: a fault turns into a reset request one cycle later
  p_fault_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fault |=> rstReq);
  // R11: a disarmed watchdog never faults
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !strobe.fault);
  // R6: a clear in the closed half of an armed period always faults
  p_closed_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wdClear && armed && !winOpen && !regWrEn) |-> strobe.fault);
endmodule

// File: rtl/winwdog_dp.sv
module winwdog_dp
  import winwdog_pkg::*;
#(
  parameter int BASE_TICKS = 4,
  localparam int MAX_LIMIT = BASE_TICKS * 14,
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [CODE_W-1:0] wrCode,
  input  wdStrobe_t         strobe,
  output logic              armed,
  output logic              winOpen,
  output logic              expire,
  output logic [7:0]        status,
  output logic [CODE_W-1:0] cycCode
);
  logic [CODE_W-1:0] wdCode;
  logic [CNT_W-1:0]  cnt, limit, half;
  logic [DIV_W-1:0]  divTab [N_CODES];
  logic              toFlag, errFlag;

  for (genvar g = 0; g < N_CODES; g++) begin : gDiv
    assign divTab[g] = (g == 0) ? DIV_W'(1) : DIV_W'(2 * g);
  end

  assign limit   = CNT_W'(BASE_TICKS * int'(divTab[wdCode]));
  assign half    = limit >> 1;
  assign winOpen = (cnt >= half);
  assign expire  = armed & tick & (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCode  <= '0;
      cycCode <= '0;
      armed   <= 1'b0;
      cnt     <= '0;
      toFlag  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.loadWd) begin
        wdCode <= wrCode;
        armed  <= 1'b1;
      end
      if (strobe.loadCyc) cycCode <= wrCode;
      if (strobe.restart)        cnt <= '0;
      else if (tick && armed)    cnt <= cnt + CNT_W'(1);
      if (strobe.fault)          toFlag <= 1'b1;
      else if (strobe.clrTo)     toFlag <= 1'b0;
      if (strobe.fault)          errFlag <= 1'b1;
      else if (strobe.clrErr)    errFlag <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_TO]   = toFlag;
    status[ST_ERR]  = errFlag;
    status[ST_OFF]  = ~armed;
    status[ST_OPEN] = armed & winOpen;
  end

  // R3: the count never reaches the period length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> cnt < limit);
  // R8: an access without a fault leaves the timeout bit clear
  p_acc_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrTo && !strobe.fault) |=> !toFlag);
  // R7: a fault sets both flags and restarts the count
  p_fault_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fault |=> (toFlag && errFlag && cnt == '0));
  // R2: a periodic-sense write leaves the watchdog code alone
  p_cyc_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCyc && !strobe.loadWd) |=> $stable(wdCode));
  // R12: without a tick or a restart the count holds
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobe.restart) |=> $stable(cnt));
endmodule

// File: rtl/winwdog.sv
module winwdog
  import winwdog_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  input  logic       wdClear,
  output logic       rstReq,
  output logic [2:0] cycCode
);
  wdStrobe_t strobe;
  logic armed, winOpen, expire;

  winwdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .selCyc(regWrData[SEL_BIT]),
    .regRdEn(regRdEn), .wdClear(wdClear), .armed(armed), .winOpen(winOpen),
    .expire(expire), .strobe(strobe), .rstReq(rstReq)
  );

  winwdog_dp #(.BASE_TICKS(BASE_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .wrCode(regWrData[CODE_W-1:0]),
    .strobe(strobe), .armed(armed), .winOpen(winOpen), .expire(expire),
    .status(regRdData), .cycCode(cycCode)
  );
endmodule

// File: tb/sim_winwdog.sv
module sim_winwdog;
  logic clk = 1'b0, rstN = 1'b0, tick = 1'b1;
  logic regWrEn = 1'b0, regRdEn = 1'b0, wdClear = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic rstReq;
  logic [2:0] cycCode;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam int expPeriod [8] = '{4, 8, 16, 24, 32, 40, 48, 56};

  always #4 clk = ~clk;

  winwdog #(.BASE_TICKS(4)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .wdClear(wdClear),
    .rstReq(rstReq), .cycCode(cycCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // count edges until rstReq is seen at a negedge; 0 if not within maxN
  task automatic waitReq(input int maxN, output int n);
    n = 0;
    for (int i = 1; i <= maxN; i++) begin
      @(negedge clk);
      if (rstReq) begin n = i; return; end
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] d, input logic rd);
    regWrEn = wr; regWrData = d; regRdEn = rd;
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
  endtask

  initial begin
    int n;
    int quiet;
    step(2);
    rstN = 1'b1;
    step(1);
    chk("R1 status", regRdData, 8'h02);
    chk("R1 rstReq", rstReq, 0);
    chk("R1 cycCode", cycCode, 0);

    // R11: disarmed watchdog ignores clears and ticks
    quiet = 0;
    for (int i = 0; i < 60; i++) begin
      wdClear = (i % 3 == 0);
      @(negedge clk);
      if (rstReq) quiet++;
    end
    wdClear = 1'b0;
    chk("R11 no reset while off", quiet, 0);
    chk("R11 status stays off", regRdData, 8'h02);

    // R2: select bit 1 loads periodic-sense code only
    access(1'b1, 8'h0D, 1'b0);
    chk("R2 cycCode load", cycCode, 5);
    chk("R2 still off", regRdData, 8'h02);

    // R3 table walk: each code gives its own period
    for (int c = 0; c < 8; c++) begin
      chk("R9 status seen during write", regRdData, (c == 0) ? 8'h02 : 8'h0C);
      access(1'b1 & 1'b1, 8'(c), 1'b0);
      chk("R8 timeout cleared by write", regRdData, (c == 0) ? 8'h00 : 8'h04);
      waitReq(80, n);
      chk("R3 period", n, expPeriod[c]);
      chk("R7 flags after timeout", regRdData, 8'h0C);
    end
    step(1);
    chk("R7 request lasts one cycle", rstReq, 0);

    // R4/R5/R10: window edges and an accepted clear (code 1, L=8)
    access(1'b1, 8'h01, 1'b0);
    step(3);
    chk("R4 closed at count 3", regRdData[0], 0);
    step(1);
    chk("R4 open at count 4", regRdData[0], 1);
    wdClear = 1'b1; @(negedge clk); wdClear = 1'b0;
    chk("R10 error cleared by good clear", regRdData, 8'h00);
    waitReq(80, n);
    chk("R5 restart after open clear", n, 8);

    // R9/R8: read returns old status then clears timeout
    chk("R9 status during read", regRdData, 8'h0C);
    access(1'b0, 8'h00, 1'b1);
    chk("R8 timeout cleared by read", regRdData, 8'h04);

    // R6: clear at count 1 (closed)
    wdClear = 1'b1; @(negedge clk); wdClear = 1'b0;
    chk("R6 closed clear faults", rstReq, 1);
    chk("R6 flags", regRdData, 8'h0C);

    // R8: read on the expiring edge, fault wins
    step(7);
    chk("R8 no early request", rstReq, 0);
    access(1'b0, 8'h00, 1'b1);
    chk("R8 expire with read", rstReq, 1);
    chk("R8 fault wins over clear", regRdData, 8'h0C);

    // R12: no ticks, no progress
    tick = 1'b0;
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rstReq) quiet++;
    end
    chk("R12 frozen without tick", quiet, 0);
    tick = 1'b1;
    waitReq(80, n);
    chk("R12 resumes full period", n, 8);

    // R2: mid-period sense write does not disturb the watchdog
    step(3);
    access(1'b1, 8'h0B, 1'b0);
    chk("R2 cycCode update", cycCode, 3);
    waitReq(80, n);
    chk("R2 period unaffected", n, 4);

    // R1: reset mid-run
    rstN = 1'b0;
    step(1);
    rstN = 1'b1;
    step(1);
    chk("R1 status after reset", regRdData, 8'h02);
    chk("R1 cycCode after reset", cycCode, 0);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule